// File: doc/BRIEF.md
# Command-Sequence Sector Write-Protect Controller

This block sits beside the front end of a word-wide memory array and observes every finished bus access. Each access arrives as a one-cycle valid strobe carrying an address, a read/write flag, the low data byte and a flag that says whether chip enable stayed low from the access before. The block looks for a fixed ordered unlock pattern. That pattern is six reads of set addresses, then a write of a new sector protection byte, a write of that byte's bitwise complement, a closing write, and a read of address zero. When the pattern is complete, the new byte becomes the protection mask. If any step is wrong, the search starts again and the mask does not change.

The mask splits the address space into equal sectors, selected by the top address bits. For every write access the block reports one of three results: the write may go to the array, the write is refused because its sector is protected, or the write belongs to the unlock pattern and must be suppressed. Reads are never held back, so the six unlock reads still return array data. The mask lives in a plain register that stands in for nonvolatile storage, and it resets to all zeros.

Top module: `wpg_sector_guard`

## Requirements
- R1: After reset, prot_mask is 00h, and no output reports a suppressed or refused access.
- R2: The mask is loaded from the protection byte, bit n protecting sector n, when the following ten valid accesses occur in order: reads of 24555h, 3AAAAh, 02333h, 1CCCCh, 000FFh, 3EF00h; a write of 3AAAAh carrying the byte; a write of 1CCCCh carrying its complement; a write of 0FF00h; and a read of 00000h.
- R3: prot_mask changes only in the cycle after an accepted final read of 00000h. Until that cycle, the previous mask keeps protecting the array.
- R4: The six unlock reads are never suppressed. The three unlock writes raise seq_suppress with arr_wr_en and wr_blocked low.
- R5: An access whose address or direction does not match the next expected step aborts the pattern and leaves the mask unchanged.
- R6: A seventh read in place of the protection-byte write aborts the pattern.
- R7: A complement write whose low byte is not the exact bitwise inverse of the pending byte aborts the pattern. That write is not suppressed.
- R8: The data of the closing write to 0FF00h has no effect on the result.
- R9: Any access other than a read of 00000h in the final step aborts the pattern, and the pending byte is discarded.
- R10: When acc_cont is high on the read of 24555h, that read starts a pattern only if the valid access just before it was a read of 00000h.
- R11: The access that causes an abort is checked again as a first step, so an aborting read of 24555h starts a new pattern.
- R12: A valid write that is not suppressed raises wr_blocked when mask bit A[17:15] is 1 and arr_wr_en otherwise. Reads raise neither.
- R13: Cycles with acc_valid low have no effect on the pattern state or the mask, and they drive all three access outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | One-cycle strobe for a completed access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_cont | input | 1 | Chip enable stayed low from the previous access |
| acc_addr | input | 18 | Word address of the access |
| acc_data | input | 8 | Low data byte of the access |
| prot_mask | output | 8 | Current sector protection mask, 1 = protected |
| seq_suppress | output | 1 | Current write is an unlock step and must not reach the array |
| arr_wr_en | output | 1 | Current write may be stored in the array |
| wr_blocked | output | 1 | Current write is refused because its sector is protected |

## Verification
The assertions assume that the access fields are steady and meaningful only while acc_valid is high, and that each strobe stands for exactly one completed access. The stimulus keeps to this. It changes inputs only between clock edges, and it drives every access for exactly one cycle with the strobe high. It also mixes in idle cycles with random-looking field values while the strobe is low, so that ignored fields are exercised. The acc_cont flag is held constant across each scenario, which matches a host that either toggles chip enable on every access or keeps it low.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
   localparam int SEQ_LEN   = 10;
   localparam int STEP_W    = 4;
   localparam int STEP_MASK = 6;
   localparam int STEP_COMP = 7;
   localparam int STEP_LAST = 9;

   typedef logic [STEP_W-1:0] step_t;

   function automatic logic [17:0] seq_addr(input step_t k);
      case (k)
         4'd0:    seq_addr = 18'h24555;
         4'd1:    seq_addr = 18'h3AAAA;
         4'd2:    seq_addr = 18'h02333;
         4'd3:    seq_addr = 18'h1CCCC;
         4'd4:    seq_addr = 18'h000FF;
         4'd5:    seq_addr = 18'h3EF00;
         4'd6:    seq_addr = 18'h3AAAA;
         4'd7:    seq_addr = 18'h1CCCC;
         4'd8:    seq_addr = 18'h0FF00;
         default: seq_addr = 18'h00000;
      endcase
   endfunction

   function automatic logic seq_is_write(input step_t k);
      seq_is_write = (k >= step_t'(STEP_MASK)) && (k < step_t'(STEP_LAST));
   endfunction
endpackage

// File: rtl/wpg_seq_fsm.sv
module wpg_seq_fsm
   import wpg_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              acc_cont,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_data,
   input  logic [DATA_W-1:0] pend_byte,
   output logic              latch_pend,
   output logic              commit,
   output logic              seq_suppress
);
   step_t step_q, step_d;
   logic  armed_q;
   logic  fresh_ok;
   logic  start_ok;
   logic  hit;
   logic  data_ok;
   logic [ADDR_W-1:0] exp_addr;
   logic [ADDR_W-1:0] first_addr;

   assign exp_addr   = ADDR_W'(seq_addr(step_q));
   assign first_addr = ADDR_W'(seq_addr(step_t'(0)));
   assign fresh_ok   = !acc_cont || armed_q;
   assign start_ok   = acc_valid && !acc_write && (acc_addr == first_addr) && fresh_ok;
   assign data_ok    = (step_q != step_t'(STEP_COMP)) || (acc_data == ~pend_byte);

   always_comb begin
      hit = acc_valid && (acc_write == seq_is_write(step_q)) &&
            (acc_addr == exp_addr) && data_ok;
      if (step_q == step_t'(0)) hit = start_ok;
   end

   always_comb begin
      step_d = step_q;
      if (acc_valid) begin
         if (hit)
            step_d = (step_q == step_t'(STEP_LAST)) ? step_t'(0) : step_q + step_t'(1);
         else
            step_d = start_ok ? step_t'(1) : step_t'(0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         step_q <= step_d;
         if (acc_valid) armed_q <= !acc_write && (acc_addr == '0);
      end
   end

   assign latch_pend   = hit && (step_q == step_t'(STEP_MASK));
   assign commit       = hit && (step_q == step_t'(STEP_LAST));
   assign seq_suppress = hit && seq_is_write(step_q);
endmodule

// File: rtl/wpg_mask_store.sv
module wpg_mask_store #(
   parameter int DATA_W = 8,
   parameter int MASK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              latch_pend,
   input  logic              commit,
   input  logic [DATA_W-1:0] acc_data,
   output logic [DATA_W-1:0] pend_byte,
   output logic [MASK_W-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_byte <= '0;
         mask      <= '0;
      end else begin
         if (latch_pend) pend_byte <= acc_data;
         if (commit)     mask      <= pend_byte[MASK_W-1:0];
      end
   end
endmodule

// File: rtl/wpg_sector_gate.sv
module wpg_sector_gate #(
   parameter int ADDR_W   = 18,
   parameter int SEC_BITS = 3,
   localparam int MASK_W  = 1 << SEC_BITS
) (
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [MASK_W-1:0] mask,
   input  logic              seq_suppress,
   output logic              arr_wr_en,
   output logic              wr_blocked
);
   logic [SEC_BITS-1:0] sec_idx;
   logic [MASK_W-1:0]   sec_hit;
   logic                prot_hit;
   logic                plain_wr;

   assign sec_idx = acc_addr[ADDR_W-1 -: SEC_BITS];

   for (genvar g = 0; g < MASK_W; g++) begin : g_sec
      assign sec_hit[g] = (sec_idx == SEC_BITS'(g)) && mask[g];
   end

   assign prot_hit   = |sec_hit;
   assign plain_wr   = acc_valid && acc_write && !seq_suppress;
   assign arr_wr_en  = plain_wr && !prot_hit;
   assign wr_blocked = plain_wr && prot_hit;
endmodule

// File: rtl/wpg_sector_guard.sv
module wpg_sector_guard #(
   parameter int ADDR_W   = 18,
   parameter int DATA_W   = 8,
   parameter int SEC_BITS = 3,
   localparam int MASK_W  = 1 << SEC_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              acc_cont,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_data,
   output logic [MASK_W-1:0] prot_mask,
   output logic              seq_suppress,
   output logic              arr_wr_en,
   output logic              wr_blocked
);
   if (ADDR_W < 18) begin : g_bad_addr
      $error("wpg_sector_guard: ADDR_W must hold the 18-bit unlock addresses");
   end
   if (MASK_W > DATA_W) begin : g_bad_mask
      $error("wpg_sector_guard: sector count exceeds the data byte width");
   end
   if (SEC_BITS < 1 || SEC_BITS > ADDR_W) begin : g_bad_sec
      $error("wpg_sector_guard: SEC_BITS out of range");
   end

   logic [DATA_W-1:0] pend_byte;
   logic              latch_pend;
   logic              commit;

   wpg_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .acc_valid   (acc_valid),
      .acc_write   (acc_write),
      .acc_cont    (acc_cont),
      .acc_addr    (acc_addr),
      .acc_data    (acc_data),
      .pend_byte   (pend_byte),
      .latch_pend  (latch_pend),
      .commit      (commit),
      .seq_suppress(seq_suppress)
   );

   wpg_mask_store #(.DATA_W(DATA_W), .MASK_W(MASK_W)) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .latch_pend(latch_pend),
      .commit    (commit),
      .acc_data  (acc_data),
      .pend_byte (pend_byte),
      .mask      (prot_mask)
   );

   wpg_sector_gate #(.ADDR_W(ADDR_W), .SEC_BITS(SEC_BITS)) gate_i (
      .acc_valid   (acc_valid),
      .acc_write   (acc_write),
      .acc_addr    (acc_addr),
      .mask        (prot_mask),
      .seq_suppress(seq_suppress),
      .arr_wr_en   (arr_wr_en),
      .wr_blocked  (wr_blocked)
   );
endmodule

// File: rtl/wpg_sector_guard_chk.sv
module wpg_sector_guard_chk #(
   parameter int ADDR_W   = 18,
   parameter int DATA_W   = 8,
   parameter int SEC_BITS = 3,
   localparam int MASK_W  = 1 << SEC_BITS
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic              acc_cont,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [DATA_W-1:0] acc_data,
   input logic [MASK_W-1:0] prot_mask,
   input logic              seq_suppress,
   input logic              arr_wr_en,
   input logic              wr_blocked
);
   // R3: the mask only moves after a read of address zero
   a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_valid && !acc_write && acc_addr == '0) |=> $stable(prot_mask));

   // R4: suppression only ever applies to writes
   a_r4_sup_write: assert property (@(posedge clk) disable iff (!rst_n)
      seq_suppress |-> (acc_valid && acc_write && !arr_wr_en && !wr_blocked));

   // R12: a refused write must sit in a protected sector
   a_r12_blk_sector: assert property (@(posedge clk) disable iff (!rst_n)
      wr_blocked |-> prot_mask[acc_addr[ADDR_W-1 -: SEC_BITS]]);

   // R12: reads raise neither array result
   a_r12_read_free: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !acc_write) |-> (!arr_wr_en && !wr_blocked && !seq_suppress));

   // R12: at most one access result at a time
   a_r12_one_result: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({seq_suppress, arr_wr_en, wr_blocked}) <= 1);

   // R13: idle cycles are inert
   a_r13_idle_out: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> (!seq_suppress && !arr_wr_en && !wr_blocked));

   a_r13_idle_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> $stable(prot_mask));
endmodule

bind wpg_sector_guard wpg_sector_guard_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_BITS(SEC_BITS)
) chk_i (.*);

// File: tb/wpg_sector_guard_tb_top.sv
`timescale 1ns/1ps
module wpg_sector_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic        acc_cont = 1'b0;
   logic [17:0] acc_addr = '0;
   logic [7:0]  acc_data = '0;
   logic [7:0]  prot_mask;
   logic        seq_suppress, arr_wr_en, wr_blocked;

   always #2.5 clk = ~clk;

   wpg_sector_guard dut_i (.*);

   int n_chk = 0;
   int n_bad = 0;

   // behavioural reference state
   int       m_step = 0;
   bit       m_armed = 0;
   bit [7:0] m_pend = 0;
   bit [7:0] m_mask = 0;
   bit       o_sup, o_arr, o_blk;

   function automatic int ref_addr(int k);
      int tab[10] = '{'h24555, 'h3AAAA, 'h02333, 'h1CCCC, 'h000FF,
                      'h3EF00, 'h3AAAA, 'h1CCCC, 'h0FF00, 'h00000};
      return tab[k];
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic acc(string req, bit v, bit w, int a, int d);
      bit start, hit, sup;
      int sec;
      @(negedge clk);
      acc_valid = v; acc_write = w; acc_addr = 18'(a); acc_data = 8'(d);
      #1;
      start = v && !w && a == 'h24555 && (!acc_cont || m_armed);
      if (m_step == 0) hit = start;
      else hit = v && (w == (m_step >= 6 && m_step <= 8)) && a == ref_addr(m_step) &&
                 (m_step != 7 || d[7:0] == ~m_pend);
      sup = hit && m_step >= 6 && m_step <= 8;
      sec = (a >> 15) & 7;
      o_sup = seq_suppress; o_arr = arr_wr_en; o_blk = wr_blocked;
      check({req, " suppress"}, seq_suppress, sup);
      check({req, " arr_wr_en"}, arr_wr_en, v && w && !sup && !m_mask[sec]);
      check({req, " wr_blocked"}, wr_blocked, v && w && !sup && m_mask[sec]);
      check({req, " mask"}, prot_mask, m_mask);
      @(posedge clk);
      if (v) begin
         if (hit) begin
            if (m_step == 6) m_pend = d[7:0];
            if (m_step == 9) m_mask = m_pend;
            m_step = (m_step == 9) ? 0 : m_step + 1;
         end else m_step = start ? 1 : 0;
         m_armed = !w && a == 0;
      end
   endtask

   task automatic idle(string req);
      acc(req, 0, 1, 'h3AAAA, 'h5A);
   endtask

   task automatic reads6(string req);
      for (int k = 0; k < 6; k++) acc(req, 0 + 1, 0, ref_addr(k), 0);
   endtask

   task automatic unlock(string req, int b, int c, int junk);
      reads6(req);
      acc(req, 1, 1, 'h3AAAA, b);
      acc(req, 1, 1, 'h1CCCC, c);
      acc(req, 1, 1, 'h0FF00, junk);
      acc(req, 1, 0, 'h00000, 0);
   endtask

   initial begin
      #50000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 mask after reset", prot_mask, 0);
      check("R1 suppress after reset", seq_suppress, 0);
      @(negedge clk) rst_n = 1'b1;

      // R12: unprotected write passes
      acc("R12", 1, 1, 'h18000, 'h11);
      check("R12 write allowed", o_arr, 1);

      // R2/R3/R4/R8: full unlock, protect sectors 3 and 4
      reads6("R4");
      check("R4 read not suppressed", o_sup, 0);
      acc("R4", 1, 1, 'h3AAAA, 'h18);
      check("R4 mask write suppressed", o_sup, 1);
      acc("R4", 1, 1, 'h1CCCC, 'hE7);
      check("R4 comp write suppressed", o_sup, 1);
      acc("R8", 1, 1, 'h0FF00, 'hC3);
      check("R3 old mask still in force", prot_mask, 0);
      acc("R2", 1, 0, 'h00000, 0);
      check("R3 mask not yet changed", prot_mask, 0);
      idle("R13");
      check("R2 mask loaded", prot_mask, 'h18);
      acc("R12", 1, 1, 'h18005, 'h22);
      check("R12 protected write refused", o_blk, 1);
      acc("R12", 1, 1, 'h20000, 'h22);
      check("R12 sector 4 refused", o_blk, 1);
      acc("R12", 1, 1, 'h08000, 'h22);
      check("R12 sector 1 allowed", o_arr, 1);

      // R13: idle gaps inside the pattern
      for (int k = 0; k < 6; k++) begin acc("R13", 1, 0, ref_addr(k), 0); idle("R13"); end
      acc("R13", 1, 1, 'h3AAAA, 'hA5); idle("R13");
      acc("R13", 1, 1, 'h1CCCC, 'h5A); idle("R13");
      acc("R13", 1, 1, 'h0FF00, 'h00); idle("R13");
      acc("R13", 1, 0, 'h00000, 0); idle("R13");
      check("R13 mask through gaps", prot_mask, 'hA5);

      // R5: wrong order
      acc("R5", 1, 0, 'h24555, 0); acc("R5", 1, 0, 'h3AAAA, 0); acc("R5", 1, 0, 'h1CCCC, 0);
      acc("R5", 1, 0, 'h000FF, 0); acc("R5", 1, 0, 'h3EF00, 0);
      acc("R5", 1, 1, 'h3AAAA, 'h01); acc("R5", 1, 1, 'h1CCCC, 'hFE);
      acc("R5", 1, 1, 'h0FF00, 0); acc("R5", 1, 0, 'h00000, 0); idle("R5");
      check("R5 mask unchanged", prot_mask, 'hA5);

      // R6: seventh read
      reads6("R6"); acc("R6", 1, 0, 'h3AAAA, 0);
      acc("R6", 1, 1, 'h3AAAA, 'h01); acc("R6", 1, 1, 'h1CCCC, 'hFE);
      acc("R6", 1, 1, 'h0FF00, 0); acc("R6", 1, 0, 'h00000, 0); idle("R6");
      check("R6 mask unchanged", prot_mask, 'hA5);

      // R7: wrong complement
      reads6("R7"); acc("R7", 1, 1, 'h3AAAA, 'h01);
      acc("R7", 1, 1, 'h1CCCC, 'hFF);
      check("R7 bad complement not suppressed", o_sup, 0);
      acc("R7", 1, 1, 'h0FF00, 0); acc("R7", 1, 0, 'h00000, 0); idle("R7");
      check("R7 mask unchanged", prot_mask, 'hA5);

      // R9: wrong final access
      reads6("R9"); acc("R9", 1, 1, 'h3AAAA, 'h01); acc("R9", 1, 1, 'h1CCCC, 'hFE);
      acc("R9", 1, 1, 'h0FF00, 0); acc("R9", 1, 0, 'h00001, 0);
      acc("R9", 1, 0, 'h00000, 0); idle("R9");
      check("R9 mask unchanged", prot_mask, 'hA5);

      // R11: aborting read of the first address restarts
      acc("R11", 1, 0, 'h24555, 0); acc("R11", 1, 0, 'h3AAAA, 0);
      unlock("R11", 'h81, 'h7E, 'h99); idle("R11");
      check("R11 restart accepted", prot_mask, 'h81);

      // R10: chip enable held low
      acc_cont = 1'b1;
      acc("R10", 1, 0, 'h12345, 0);
      unlock("R10", 'h0F, 'hF0, 0); idle("R10");
      check("R10 no lead-in read refused", prot_mask, 'h81);
      acc("R10", 1, 0, 'h00000, 0);
      unlock("R10", 'h0F, 'hF0, 'hFF); idle("R10");
      check("R10 lead-in read accepted", prot_mask, 'h0F);
      acc_cont = 1'b0;

      // back to no protection
      unlock("R2", 'h00, 'hFF, 'h3C); idle("R2");
      check("R2 mask cleared", prot_mask, 'h00);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule